// File: doc/BRIEF.md
# Skip-Under-Mask Predication Unit

This unit sits next to the issue/retire point of an in-order pipeline. It decides, one instruction at a time, whether each instruction is squashed into a no-op. This lets software predicate a short run of upcoming instructions without condition flags or branches.

The unit holds a kill window of `WIN` bits. Bit 0 of the window belongs to the instruction now executing, and higher bits belong to the instructions after it. A compare-and-mask instruction compares two register operands. If the comparison is true, its immediate pattern is merged into the window. Pattern bit k selects the (k+1)-th instruction after the compare.

Each executed instruction shifts the window down by one position, whether that instruction ran or was squashed. Nothing but reset clears the window, so pending kill bits stay in force across taken jumps. A squashed instruction has its register writeback enable forced low.

Top module: `skip_mask_unit`

## Requirements
- R1: After reset is released, no instruction is squashed until a compare-and-mask instruction with a true condition has executed.
- R2: `kill_o` is high only on a cycle with `exec_valid_i` high, and it reflects the kill bit for the current instruction as held before that cycle's shift.
- R3: Every executed instruction advances the window by one position, squashed instructions included. Positions that enter the window are zero.
- R4: While `exec_valid_i` is low the window holds its contents, and no pending kill is consumed.
- R5: A compare-and-mask instruction that executes unsquashed with a true condition squashes the (k+1)-th following instruction for every set bit k of `pattern_i`.
- R6: A compare-and-mask instruction whose condition is false leaves the window unchanged apart from the shift.
- R7: A compare-and-mask instruction that is itself squashed does not load its pattern, even when its condition is true.
- R8: A pattern loaded while kill bits are still pending is OR-ed into the shifted window, so the two predicated regions overlap.
- R9: `cond_i` selects the comparison: 0 means operands equal, 1 means operands differ, 2 means a less than b as signed two's-complement, and 3 means a less than b unsigned.
- R10: `wb_en_o` equals `wb_en_i` unless `kill_o` is high, in which case `wb_en_o` is low.
- R11: `pattern_i`, `cond_i` and the operands have no effect when `is_cmask_i` is low.
- R12: Pattern bit `WIN-1` squashes exactly the `WIN`-th following instruction and no earlier or later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_valid_i | input | 1 | An instruction executes this cycle |
| is_cmask_i | input | 1 | The executing instruction is a compare-and-mask |
| cond_i | input | 2 | Comparison select (see R9) |
| opa_i | input | DATA_W | First compare operand |
| opb_i | input | DATA_W | Second compare operand |
| pattern_i | input | WIN | Kill pattern; bit k selects the (k+1)-th following instruction |
| wb_en_i | input | 1 | Writeback enable from decode |
| kill_o | output | 1 | Current instruction is squashed |
| wb_en_o | output | 1 | Gated writeback enable |

## Verification
The bench aims at the points where a plausible implementation goes wrong:
- If shifting only on unsquashed instructions, back-to-back kills would drift one instruction late.
- If the window advanced during stalls, a pending kill would be lost.
- If a squashed compare still loaded its pattern, extra instructions would be killed.
- If a new pattern overwrote the window instead of merging with it, the earlier region's later kills would be dropped.

It also checks the signed versus unsigned compare on operands whose sign bit is set, where the two orders disagree. It checks the last window bit, which an off-by-one shift would miss or misplace.

// File: rtl/skm_pkg.sv
package skm_pkg;
  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_NE  = 2'd1,
    CMP_LTS = 2'd2,
    CMP_LTU = 2'd3
  } cmp_e;
endpackage

// File: rtl/skm_cond_eval.sv
module skm_cond_eval
  import skm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cmp_e              cond_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              hit_o
);
  logic eq, lts, ltu;

  assign eq  = (opa_i == opb_i);
  assign lts = ($signed(opa_i) < $signed(opb_i));
  assign ltu = (opa_i < opb_i);

  always_comb begin
    unique case (cond_i)
      CMP_EQ:  hit_o = eq;
      CMP_NE:  hit_o = ~eq;
      CMP_LTS: hit_o = lts;
      CMP_LTU: hit_o = ltu;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/skm_mask_reg.sv
module skm_mask_reg #(
  parameter int WIN = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           load_i,
  input  logic [WIN-1:0] pat_i,
  output logic [WIN-1:0] mask_o
);
  logic [WIN-1:0] mask_q, shifted, merged;

  assign shifted = mask_q >> 1;
  assign merged  = load_i ? (shifted | pat_i) : shifted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (adv_i) mask_q <= merged;
  end

  assign mask_o = mask_q;

  a_r4_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(mask_q));

  a_r3_plain_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (mask_q == ($past(mask_q) >> 1)));

  a_r5_pattern_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && load_i) |=> ((mask_q & $past(pat_i)) == $past(pat_i)));
endmodule

// File: rtl/skip_mask_unit.sv
module skip_mask_unit
  import skm_pkg::*;
#(
  parameter int WIN    = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_valid_i,
  input  logic              is_cmask_i,
  input  logic [1:0]        cond_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [WIN-1:0]    pattern_i,
  input  logic              wb_en_i,
  output logic              kill_o,
  output logic              wb_en_o
);
  logic           hit, load;
  logic [WIN-1:0] mask;

  skm_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .cond_i (cmp_e'(cond_i)),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .hit_o  (hit)
  );

  // kill bit is sampled before this cycle's shift
  assign kill_o  = exec_valid_i & mask[0];
  assign load    = exec_valid_i & is_cmask_i & hit & ~mask[0];
  assign wb_en_o = wb_en_i & ~kill_o;

  skm_mask_reg #(.WIN(WIN)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (exec_valid_i),
    .load_i (load),
    .pat_i  (pattern_i),
    .mask_o (mask)
  );

  a_r7_squashed_cmask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_i && is_cmask_i && kill_o) |=> (mask == ($past(mask) >> 1)));

  a_r10_wb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_o |-> !wb_en_o);
endmodule

// File: tb/tb_skip_mask_unit.sv
module tb_skip_mask_unit;
  localparam int WIN = 8;
  localparam int DW  = 32;
  localparam time TCK = 20ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev = 1'b0, cm = 1'b0, wb = 1'b0;
  logic [1:0]    cnd = 2'd0;
  logic [DW-1:0] a = '0, b = '0;
  logic [WIN-1:0] pat = '0;
  logic          kill, wbo;
  int n_chk = 0, n_fail = 0;

  always #(TCK/2) clk = ~clk;

  skip_mask_unit #(.WIN(WIN), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_valid_i(ev), .is_cmask_i(cm),
    .cond_i(cnd), .opa_i(a), .opb_i(b), .pattern_i(pat), .wb_en_i(wb),
    .kill_o(kill), .wb_en_o(wbo));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // one executed instruction; checks kill and gated writeback before the edge
  task automatic step(input string req, input logic c, input logic [1:0] cc,
                      input logic [DW-1:0] x, input logic [DW-1:0] y,
                      input logic [WIN-1:0] p, input logic exp_kill);
    @(negedge clk);
    ev = 1'b1; cm = c; cnd = cc; a = x; b = y; pat = p; wb = 1'b1;
    #1;
    chk(req, kill, exp_kill);
    chk("R10", wbo, ~exp_kill);
    @(posedge clk);
    #1 ev = 1'b0; cm = 1'b0; pat = '0;
  endtask

  task automatic plain(input string req, input logic exp_kill);
    step(req, 1'b0, 2'd0, 0, 0, '0, exp_kill);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ev = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < WIN + 1; i++) plain("R1", 1'b0);
  endtask

  task automatic t_basic();
    step("R5", 1'b1, 2'd0, 5, 5, 8'b0000_0101, 1'b0);
    plain("R5", 1'b1); plain("R3", 1'b0); plain("R5", 1'b1); plain("R3", 1'b0);
  endtask

  task automatic t_false();
    step("R6", 1'b1, 2'd0, 5, 6, 8'hff, 1'b0);
    for (int i = 0; i < WIN; i++) plain("R6", 1'b0);
  endtask

  task automatic cond_case(input logic [1:0] cc, input logic [DW-1:0] x,
                           input logic [DW-1:0] y, input logic hit);
    step("R9", 1'b1, cc, x, y, 8'b1, 1'b0);
    plain("R9", hit);
  endtask

  task automatic t_conds();
    cond_case(2'd0, 7, 7, 1'b1);
    cond_case(2'd1, 7, 7, 1'b0);
    cond_case(2'd1, 7, 9, 1'b1);
    cond_case(2'd2, 32'hffff_ffff, 1, 1'b1);
    cond_case(2'd2, 1, 32'hffff_ffff, 1'b0);
    cond_case(2'd3, 32'hffff_ffff, 1, 1'b0);
    cond_case(2'd3, 1, 32'hffff_ffff, 1'b1);
    cond_case(2'd2, 3, 3, 1'b0);
  endtask

  task automatic t_stall();
    step("R4", 1'b1, 2'd0, 1, 1, 8'b0000_0010, 1'b0);
    plain("R4", 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ev = 1'b0; wb = 1'b1; #1;
      chk("R2", kill, 1'b0);
    end
    plain("R4", 1'b1);
    plain("R4", 1'b0);
  endtask

  task automatic t_shift_killed();
    step("R3", 1'b1, 2'd0, 0, 0, 8'b0000_0011, 1'b0);
    plain("R3", 1'b1); plain("R3", 1'b1); plain("R3", 1'b0);
  endtask

  task automatic t_killed_cmask();
    step("R7", 1'b1, 2'd0, 0, 0, 8'b0000_0001, 1'b0);
    step("R7", 1'b1, 2'd0, 4, 4, 8'hff, 1'b1);
    for (int i = 0; i < WIN; i++) plain("R7", 1'b0);
  endtask

  task automatic t_overlap();
    step("R8", 1'b1, 2'd0, 2, 2, 8'b0000_0100, 1'b0);
    step("R8", 1'b1, 2'd0, 2, 2, 8'b0000_0001, 1'b0);
    plain("R8", 1'b1); plain("R8", 1'b1); plain("R8", 1'b0);
  endtask

  task automatic t_ignored();
    step("R11", 1'b0, 2'd0, 9, 9, 8'hff, 1'b0);
    for (int i = 0; i < WIN; i++) plain("R11", 1'b0);
  endtask

  task automatic t_window();
    step("R12", 1'b1, 2'd0, 0, 0, 8'b1000_0000, 1'b0);
    for (int i = 0; i < WIN - 1; i++) plain("R12", 1'b0);
    plain("R12", 1'b1);
    plain("R12", 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_false();
    t_conds();
    t_stall();
    t_shift_killed();
    t_killed_cmask();
    t_overlap();
    t_ignored();
    t_window();
    step("R1", 1'b1, 2'd0, 0, 0, 8'b0000_0001, 1'b0);
    do_reset();
    plain("R1", 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule